// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes incoming frames as a byte stream and files each one into a ring of receive descriptors, with one fixed-size data buffer per descriptor. The descriptors and buffers live in a byte-wide local memory that the block reaches through a single read/write port. The descriptors sit at the bottom of that memory, eight bytes each. Buffer `i` starts at `RING_N*8 + i*BUF_BYTES`.

The engine hunts for a descriptor whose flag byte marks it as owned by the engine. The hunt starts at its ring pointer. A found slot is held armed, and `rx_ready` is raised. The next frame is then streamed into that slot's buffer. After the frame, the engine writes the stored byte count and then returns the slot by rewriting its flag byte. In the cycle of that flag write it pulses `rx_irq`.

A frame that begins while the block runs but no slot is armed is dropped whole, and `rx_miss` pulses. While `run` is low the engine idles, keeps `rx_ready` low and silently discards frames.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, `rx_ready`, `mem_re`, `mem_we`, `rx_irq` and `rx_miss` are low, and the ring pointer is 0, so the first stored frame goes to the first owned slot found from index 0.
- R2: A slot qualifies only when its flag byte (byte offset 2 of the eight-byte descriptor at address `index*8`) is exactly 0x80. Any other value, 0x81 included, is skipped. Flag reads are issued with `mem_re`, and data returns on `mem_rdata` one cycle later.
- R3: The hunt covers at most RING_N-1 slots, in order from the ring pointer p: p, p+1, ..., p+RING_N-2 (mod RING_N). The slot at p-1 is never taken, even when it is the only owned one.
- R4: `rx_ready` is high exactly while a qualifying slot is armed, the block runs, and no dropped frame is still streaming. It stays low while no slot in the hunted window qualifies.
- R5: Each accepted byte is written in the same cycle it is presented. It goes to address `RING_N*8 + slot*BUF_BYTES + offset`, with offset counting from 0.
- R6: Bytes past `BUF_BYTES` (1544) are discarded. The stored count (16 bits) is written big-endian: the high byte at descriptor offset 6, and the low byte at offset 7 in the next cycle.
- R7: In the cycle after the count's low byte, flag byte 0x03 is written to descriptor offset 2 and `rx_irq` pulses for that one cycle. `rx_irq` never pulses at any other time.
- R8: Each stored frame advances the ring pointer by exactly one (mod RING_N), whichever slot received it.
- R9: While `run` is low, `rx_ready` is low, and frames cause no memory write, no `rx_irq` and no `rx_miss`.
- R10: When the block runs and a frame's first byte arrives with no armed slot, `rx_miss` pulses in that cycle. No byte of that frame is written, and its remaining bytes are ignored up to its last flag.
- R11: Ring indices wrap modulo RING_N, for both the ring pointer and the hunt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Engine enabled; low means stopped |
| in_valid | input | 1 | Frame byte present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | A slot is armed; a frame started now is stored |
| mem_re | output | 1 | Flag-byte read request |
| mem_we | output | 1 | Byte write request |
| mem_addr | output | ADDR_W (15) | Byte address into descriptor/buffer memory |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| rx_irq | output | 1 | One-cycle receive-done strobe |
| rx_miss | output | 1 | One-cycle strobe for a frame dropped for lack of a slot |

## Verification
The tail of a stored frame can collide with the head of the next one. The count and flag writes of frame A occupy the three cycles after A's last byte. A first byte of frame B arriving in that window must be reported as a miss while A's writes carry on. The bench provokes this by starting B in the cycle right after A's last byte. It judges the result by checking three things: every write of A still arrives in order at the right address, `rx_miss` pulses in the cycle B starts, and no byte of B is written.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [2:0] {
      ST_HALT,
      ST_PEEK,
      ST_JUDGE,
      ST_ARMED,
      ST_FILL,
      ST_LEN_HI,
      ST_LEN_LO,
      ST_CLOSE
   } rxr_state_e;

   localparam int         DESC_BYTES = 8;
   localparam logic [2:0] OFS_FLAG   = 3'd2;
   localparam logic [2:0] OFS_CNT_HI = 3'd6;
   localparam logic [2:0] OFS_CNT_LO = 3'd7;
   localparam logic [7:0] FLAG_OWNED = 8'h80;
   localparam logic [7:0] FLAG_DONE  = 8'h03;

endpackage

// File: rtl/rxr_qualify.sv
module rxr_qualify #(
   parameter bit EXACT_OWN = 1'b1
) (
   input  logic [7:0] flag_byte,
   output logic       usable
);

   generate
      if (EXACT_OWN) begin : g_exact
         // only the pure ownership value counts; any other flag set disqualifies
         assign usable = (flag_byte == rxr_pkg::FLAG_OWNED);
      end else begin : g_own_bit
         assign usable = flag_byte[7];
      end
   endgenerate

endmodule

// File: rtl/rxr_scan.sv
module rxr_scan #(
   parameter  int RING_N = 16,
   localparam int IDX_W  = $clog2(RING_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   input  logic             latch,
   input  logic             advance,
   output logic [IDX_W-1:0] probe_idx,
   output logic [IDX_W-1:0] cand_idx,
   output logic             probe_final
);

   logic [IDX_W-1:0] ring_ptr;
   logic [IDX_W-1:0] hop;

   // index arithmetic wraps by itself because RING_N is a power of two
   assign probe_idx   = ring_ptr + hop;
   assign probe_final = (hop == IDX_W'(RING_N - 2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_ptr <= '0;
         hop      <= '0;
         cand_idx <= '0;
      end else begin
         if (restart)
            hop <= '0;
         else if (step)
            hop <= hop + 1'b1;
         if (latch)
            cand_idx <= probe_idx;
         if (advance)
            ring_ptr <= ring_ptr + 1'b1;
      end
   end

endmodule

// File: rtl/rxr_fill.sv
module rxr_fill #(
   parameter  int BUF_BYTES = 1544,
   localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   output logic [CNT_W-1:0] count,
   output logic             room
);

   assign room = (count < CNT_W'(BUF_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (clear)
         count <= '0;
      else if (take && room)
         count <= count + 1'b1;
   end

endmodule

// File: rtl/rxr_addr.sv
module rxr_addr #(
   parameter  int RING_N     = 16,
   parameter  int BUF_BYTES  = 1544,
   localparam int IDX_W      = $clog2(RING_N),
   localparam int CNT_W      = $clog2(BUF_BYTES + 1),
   localparam int RING_BYTES = RING_N * rxr_pkg::DESC_BYTES,
   localparam int ADDR_W     = $clog2(RING_BYTES + RING_N * BUF_BYTES)
) (
   input  logic              to_buf,
   input  logic [IDX_W-1:0]  idx,
   input  logic [2:0]        ofs,
   input  logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] addr
);

   localparam bit BUF_POW2 = ((BUF_BYTES & (BUF_BYTES - 1)) == 0);

   logic [ADDR_W-1:0] desc_addr;
   logic [ADDR_W-1:0] slot_base;

   assign desc_addr = ADDR_W'({idx, ofs});

   generate
      if (BUF_POW2) begin : g_shift
         assign slot_base = ADDR_W'(idx) << $clog2(BUF_BYTES);
      end else begin : g_mult
         assign slot_base = ADDR_W'(idx) * ADDR_W'(BUF_BYTES);
      end
   endgenerate

   assign addr = to_buf ? (ADDR_W'(RING_BYTES) + slot_base + ADDR_W'(cnt))
                        : desc_addr;

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
   parameter  int RING_N     = 16,
   parameter  int BUF_BYTES  = 1544,
   parameter  bit EXACT_OWN  = 1'b1,
   localparam int IDX_W      = $clog2(RING_N),
   localparam int CNT_W      = $clog2(BUF_BYTES + 1),
   localparam int RING_BYTES = RING_N * rxr_pkg::DESC_BYTES,
   localparam int ADDR_W     = $clog2(RING_BYTES + RING_N * BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              rx_ready,
   output logic              mem_re,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              rx_irq,
   output logic              rx_miss
);

   import rxr_pkg::*;

   generate
      if (RING_N < 2 || (RING_N & (RING_N - 1)) != 0) begin : g_bad_ring
         $error("rx_ring_engine: RING_N must be a power of two, at least 2");
      end
      if (BUF_BYTES < 1 || BUF_BYTES > 65535) begin : g_bad_buf
         $error("rx_ring_engine: BUF_BYTES must fit the 16-bit count field");
      end
   endgenerate

   rxr_state_e       state, state_d;
   logic             drop_q, drop_d;
   logic             scan_restart, scan_step, scan_latch, scan_adv;
   logic             fill_clear, fill_take, fill_room;
   logic [CNT_W-1:0] fill_cnt;
   logic [15:0]      cnt16;
   logic [IDX_W-1:0] probe_idx, cand_idx, addr_idx;
   logic             probe_final, probe_hit;
   logic             frame_open, frame_start, take_first;
   logic             addr_buf;
   logic [2:0]       addr_ofs;

   rxr_scan #(.RING_N(RING_N)) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (scan_restart),
      .step        (scan_step),
      .latch       (scan_latch),
      .advance     (scan_adv),
      .probe_idx   (probe_idx),
      .cand_idx    (cand_idx),
      .probe_final (probe_final)
   );

   rxr_qualify #(.EXACT_OWN(EXACT_OWN)) u_qual (
      .flag_byte (mem_rdata),
      .usable    (probe_hit)
   );

   rxr_fill #(.BUF_BYTES(BUF_BYTES)) u_fill (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (fill_clear),
      .take  (fill_take),
      .count (fill_cnt),
      .room  (fill_room)
   );

   rxr_addr #(.RING_N(RING_N), .BUF_BYTES(BUF_BYTES)) u_addr (
      .to_buf (addr_buf),
      .idx    (addr_idx),
      .ofs    (addr_ofs),
      .cnt    (fill_cnt),
      .addr   (mem_addr)
   );

   assign cnt16 = 16'(fill_cnt);

   // frame framing: a frame is open while being stored or while being dropped
   assign frame_open  = (state == ST_FILL) || drop_q;
   assign frame_start = in_valid && !frame_open;
   assign take_first  = frame_start && (state == ST_ARMED) && run;
   assign rx_miss     = frame_start && run && (state != ST_ARMED);
   assign rx_ready    = (state == ST_ARMED) && run && !drop_q;

   always_comb begin
      if (drop_q)
         drop_d = !(in_valid && in_last);
      else
         drop_d = frame_start && !take_first && !in_last;
   end

   // sequencing
   always_comb begin
      state_d      = state;
      scan_restart = 1'b0;
      scan_step    = 1'b0;
      scan_latch   = 1'b0;
      scan_adv     = 1'b0;
      fill_clear   = 1'b0;
      unique case (state)
         ST_HALT: begin
            scan_restart = 1'b1;
            if (run)
               state_d = ST_PEEK;
         end
         ST_PEEK: begin
            state_d = run ? ST_JUDGE : ST_HALT;
         end
         ST_JUDGE: begin
            if (!run) begin
               state_d = ST_HALT;
            end else if (probe_hit) begin
               scan_latch = 1'b1;
               state_d    = ST_ARMED;
            end else if (probe_final) begin
               scan_restart = 1'b1;
               state_d      = ST_PEEK;
            end else begin
               scan_step = 1'b1;
               state_d   = ST_PEEK;
            end
         end
         ST_ARMED: begin
            if (take_first)
               state_d = in_last ? ST_LEN_HI : ST_FILL;
            else if (!run)
               state_d = ST_HALT;
         end
         ST_FILL: begin
            if (in_valid && in_last)
               state_d = ST_LEN_HI;
         end
         ST_LEN_HI: state_d = ST_LEN_LO;
         ST_LEN_LO: state_d = ST_CLOSE;
         ST_CLOSE: begin
            scan_adv     = 1'b1;
            scan_restart = 1'b1;
            fill_clear   = 1'b1;
            state_d      = run ? ST_PEEK : ST_HALT;
         end
         default: state_d = ST_HALT;
      endcase
   end

   // memory port steering
   always_comb begin
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = 8'h00;
      rx_irq    = 1'b0;
      fill_take = 1'b0;
      addr_buf  = 1'b0;
      addr_idx  = cand_idx;
      addr_ofs  = OFS_FLAG;
      unique case (state)
         ST_PEEK: begin
            mem_re   = 1'b1;
            addr_idx = probe_idx;
         end
         ST_ARMED: begin
            if (take_first) begin
               mem_we    = 1'b1;
               mem_wdata = in_data;
               addr_buf  = 1'b1;
               fill_take = 1'b1;
            end
         end
         ST_FILL: begin
            if (in_valid && fill_room) begin
               mem_we    = 1'b1;
               mem_wdata = in_data;
               addr_buf  = 1'b1;
               fill_take = 1'b1;
            end
         end
         ST_LEN_HI: begin
            mem_we    = 1'b1;
            mem_wdata = cnt16[15:8];
            addr_ofs  = OFS_CNT_HI;
         end
         ST_LEN_LO: begin
            mem_we    = 1'b1;
            mem_wdata = cnt16[7:0];
            addr_ofs  = OFS_CNT_LO;
         end
         ST_CLOSE: begin
            mem_we    = 1'b1;
            mem_wdata = FLAG_DONE;
            rx_irq    = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_HALT;
         drop_q <= 1'b0;
      end else begin
         state  <= state_d;
         drop_q <= drop_d;
      end
   end

endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk #(
   parameter int RING_BYTES = 128,
   parameter int ADDR_W     = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              in_valid,
   input logic              rx_ready,
   input logic              mem_re,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              rx_irq,
   input logic              rx_miss
);

   logic desc_lo_write;
   assign desc_lo_write = mem_we && (int'(mem_addr) < RING_BYTES) && (mem_addr[2:0] == 3'd7);

   AST_PEEK_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> (!mem_we && mem_addr[2:0] == 3'd2 && int'(mem_addr) < RING_BYTES)); // R2

   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !in_valid) |=> (rx_ready || !run)); // R4

   AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && in_valid) |-> (mem_we && !rx_miss)); // R5

   AST_IRQ_IS_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (mem_we && mem_wdata == 8'h03 && mem_addr[2:0] == 3'd2)); // R7

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq); // R7

   AST_COUNT_THEN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      desc_lo_write |=> rx_irq); // R7

   AST_STOP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!rx_ready && !rx_miss)); // R9

   AST_MISS_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_miss |-> !rx_ready); // R10

endmodule

bind rx_ring_engine rx_ring_engine_chk #(
   .RING_BYTES (RING_BYTES),
   .ADDR_W     (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .in_valid  (in_valid),
   .rx_ready  (rx_ready),
   .mem_re    (mem_re),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .rx_irq    (rx_irq),
   .rx_miss   (rx_miss)
);

// File: tb/test_rx_ring_engine.sv
module test_rx_ring_engine;

   localparam int RN = 16;
   localparam int BB = 1544;
   localparam int RB = RN * 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_last = 1'b0;
   logic        rx_ready, mem_re, mem_we, rx_irq, rx_miss;
   logic [14:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;

   rx_ring_engine i_rx_ring_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_last   (in_last),
      .rx_ready  (rx_ready),
      .mem_re    (mem_re),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .rx_irq    (rx_irq),
      .rx_miss   (rx_miss)
   );

   always #5 clk = ~clk;

   // behavioural descriptor/buffer memory, one-cycle read latency
   logic [7:0] mem [int];

   function automatic logic [7:0] peek(int a);
      if (mem.exists(a)) return mem[a];
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= peek(int'(mem_addr));
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
   end

   int    n_chk  = 0;
   int    n_fail = 0;
   int    ptr    = 0;
   int    qa[$];
   int    qd[$];
   bit    qi[$];
   string qs[$];

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, compare in mid-cycle
   task automatic tick(logic v, logic [7:0] d, logic l, logic miss_exp, string mtag);
      int    ea, ed;
      bit    ei;
      string es;
      @(negedge clk);
      in_valid = v;
      in_data  = d;
      in_last  = l;
      #2;
      if (mem_we === 1'b1) begin
         if (qa.size() == 0) begin
            check("R5 unexpected write", 1, 0);
         end else begin
            ea = qa.pop_front();
            ed = qd.pop_front();
            ei = qi.pop_front();
            es = qs.pop_front();
            check({es, " addr"}, int'(mem_addr), ea);
            check({es, " wdata"}, int'(mem_wdata), ed);
            check("R7 irq with write", int'(rx_irq), int'(ei));
         end
      end else begin
         check("R7 irq without write", int'(rx_irq), 0);
      end
      check(mtag, int'(rx_miss), int'(miss_exp));
   endtask

   task automatic idle(int n, string mtag);
      for (int c = 0; c < n; c++) tick(1'b0, 8'h00, 1'b0, 1'b0, mtag);
   endtask

   function automatic int find_slot();
      for (int k = 0; k < RN - 1; k++) begin
         int i;
         i = (ptr + k) % RN;
         if (peek(i * 8 + 2) == 8'h80) return i;
      end
      return -1;
   endfunction

   function automatic logic [7:0] pat(int seed, int i);
      return 8'((seed + i * 7) & 8'hff);
   endfunction

   task automatic send(int len, int seed, int tail, string why);
      int idx, stored, w;
      idx = (run === 1'b1) ? find_slot() : -1;
      if (idx >= 0) begin
         for (w = 0; w < 80 && rx_ready !== 1'b1; w++) idle(1, "R10 no miss while waiting");
         check({why, " R4 ready armed"}, int'(rx_ready), 1);
         stored = (len > BB) ? BB : len;
         for (int i = 0; i < stored; i++) begin
            qa.push_back(RB + idx * BB + i); qd.push_back(int'(pat(seed, i)));
            qi.push_back(1'b0); qs.push_back({why, " data"});
         end
         qa.push_back(idx * 8 + 6); qd.push_back((stored >> 8) & 255); qi.push_back(1'b0); qs.push_back("R6 count high");
         qa.push_back(idx * 8 + 7); qd.push_back(stored & 255);        qi.push_back(1'b0); qs.push_back("R6 count low");
         qa.push_back(idx * 8 + 2); qd.push_back(3);                   qi.push_back(1'b1); qs.push_back("R7 flag");
         for (int i = 0; i < len; i++)
            tick(1'b1, pat(seed, i), i == len - 1, 1'b0, "R10 no miss while storing");
         for (int i = 0; i < tail; i++)
            tick(1'b1, pat(seed + 99, i), i == tail - 1, i == 0, "R10 miss during close");
         for (int c = 0; c < 6 && qa.size() > 0; c++) idle(1, "R10 no miss");
         check("R7 all writes seen", qa.size(), 0);
         idle(1, "R10 no miss");
         check("R7 flag returned", int'(peek(idx * 8 + 2)), 3);
         ptr = (ptr + 1) % RN;
      end else begin
         idle(80, "R10 no miss while empty");
         check(why, int'(rx_ready), 0);
         for (int i = 0; i < len; i++)
            tick(1'b1, pat(seed, i), i == len - 1, (i == 0) && (run === 1'b1),
                 (run === 1'b1) ? "R10 miss on empty ring" : "R9 stopped no miss");
         idle(4, "R9 R10 quiet after drop");
      end
   endtask

   initial begin
      mem[0 * 8 + 2] = 8'h80;
      mem[3 * 8 + 2] = 8'h81;
      mem[5 * 8 + 2] = 8'h80;
      idle(3, "R1 no miss in reset");
      rst_n = 1'b1;
      idle(4, "R1 no miss after reset");
      check("R1 ready after reset", int'(rx_ready), 0);
      check("R1 no read after reset", int'(mem_re), 0);
      check("R1 no write after reset", int'(mem_we), 0);

      send(6, 1, 0, "R9 stopped ready low");
      @(negedge clk) run = 1'b1;
      send(10, 2, 0, "R1 first slot");
      send(64, 3, 0, "R2 skip non-exact flag");
      send(5, 4, 0, "R4 ready low on empty ring");
      mem[1 * 8 + 2] = 8'h80;
      send(8, 5, 0, "R3 slot behind pointer unused");
      mem[15 * 8 + 2] = 8'h80;
      send(12, 6, 0, "R8 pointer steps by one");
      send(1600, 7, 0, "R6 truncation");
      mem[6 * 8 + 2] = 8'h80;
      mem[7 * 8 + 2] = 8'h80;
      send(5, 8, 4, "R5 back to back");
      for (int n = 0; n < 14; n++) begin
         if (find_slot() < 0) mem[((ptr + 3) % RN) * 8 + 2] = 8'h80;
         send(1 + n, 20 + n, 0, "R11 wrap");
      end
      @(negedge clk) run = 1'b0;
      mem[((ptr + 2) % RN) * 8 + 2] = 8'h80;
      send(4, 40, 0, "R9 stopped with owned slot");
      @(negedge clk) run = 1'b1;
      send(4, 41, 0, "R9 resume");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule